// File: doc/BRIEF.md
# MSI Home Directory Controller

This block is the home node for a small group of cache lines shared by a fixed number of caches under an MSI write-invalidate protocol. For each line it keeps a coherence state, a sharer bit-vector and a one-hot owner vector. It takes three kinds of input: cache requests (read-shared, read-exclusive, clean eviction, dirty eviction), data returned by a former owner, and memory responses (read data or write acknowledge). From these it issues memory reads and writes, forwards and invalidates to caches, data responses to requesters and eviction acknowledges.

While a line waits on memory or on a former owner it is transient. A read-shared or read-exclusive request to such a line stays at the head of the request channel until the line settles. All other traffic keeps flowing. Each channel uses a valid/ready handshake. At most one message is consumed per cycle, and memory responses take priority over cache data, which takes priority over requests. Any message that does not fit the line's state is consumed without effect and raises a one-cycle error pulse.

Top module: `msi_directory`

## Requirements
- R1: After reset every line is invalid with no sharers or owner, every output valid is low and `err` is low.
- R2: A read-shared request (`req_type`=0) to a line that is invalid or shared issues a memory read (`mem_req_write`=0) and adds the requester to the sharers. The memory read data that follows is sent on the data channel to that requester with `dat_acks`=0, and the line becomes shared.
- R3: A read-exclusive request (`req_type`=1) to an invalid or shared line issues a memory read and makes the requester the only owner. From a shared line it also sends one invalidate (`fwd_kind`=2) whose `fwd_dest` vector holds every sharer except the requester. When memory data arrives, `dat_acks` equals the number of other sharers, the sharers are cleared and the line becomes modified.
- R4: A read-shared request to a modified line forwards it to the owner (`fwd_kind`=0, `fwd_src` = requester), makes owner and requester sharers and waits for owner data. That data is written to memory, and the write acknowledge makes the line shared. A read-exclusive request to a modified line is forwarded to the old owner (`fwd_kind`=1) and the requester becomes owner, with no memory access.
- R5: A dirty eviction (`req_type`=3) from the owner of a modified line writes `req_data` to memory, clears the owner and sends an eviction acknowledge. The write acknowledge then makes the line invalid.
- R6: A clean eviction (`req_type`=2) counts as last when the line has exactly one sharer. In the shared state a last eviction acknowledges and makes the line invalid. A not-last eviction, or a dirty eviction from a non-owner, in the shared or shared-pending states removes the requester and acknowledges.
- R7: A read-shared or read-exclusive request to a line that is waiting on memory or on owner data is not consumed (`req_ready` low).
- R8: In one cycle a memory response is taken before a cache data message, and a cache data message before a request. The lower-priority messages are held.
- R9: Any eviction to an invalid line, and a clean or non-owner dirty eviction to a modified or modified-pending line, produces only an eviction acknowledge to the requester.
- R10: A message that is illegal for the line's state is consumed with no output and no state change, and `err` is high for the following cycle. Examples are memory data to an invalid line, and a last clean eviction while a read is pending.
- R11: An output whose ready is low keeps its valid and fields unchanged. No message is consumed while any output slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Cache request consumed this cycle |
| req_type | input | 2 | 0 read-shared, 1 read-exclusive, 2 clean evict, 3 dirty evict |
| req_line | input | LW | Line index |
| req_src | input | CW | Requesting cache index |
| req_data | input | DW | Eviction data |
| cdat_valid | input | 1 | Data from former owner present |
| cdat_ready | output | 1 | Owner data consumed |
| cdat_line | input | LW | Line index of owner data |
| cdat_data | input | DW | Owner data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_ready | output | 1 | Memory response consumed |
| mem_rsp_ack | input | 1 | 1 write acknowledge, 0 read data |
| mem_rsp_line | input | LW | Line index of memory response |
| mem_rsp_data | input | DW | Memory read data |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_line | output | LW | Memory request line |
| mem_req_data | output | DW | Write data |
| fwd_valid | output | 1 | Forward/invalidate pending |
| fwd_ready | input | 1 | Forward accepted |
| fwd_kind | output | 2 | 0 forward read-shared, 1 forward read-exclusive, 2 invalidate |
| fwd_line | output | LW | Forwarded line |
| fwd_dest | output | NCACHE | Destination cache vector |
| fwd_src | output | CW | Original requester |
| dat_valid | output | 1 | Data response pending |
| dat_ready | input | 1 | Data response accepted |
| dat_dest | output | CW | Requester receiving data |
| dat_line | output | LW | Data line |
| dat_data | output | DW | Data value |
| dat_acks | output | AW | Invalidate acknowledges to expect |
| pack_valid | output | 1 | Eviction acknowledge pending |
| pack_ready | input | 1 | Eviction acknowledge accepted |
| pack_dest | output | CW | Evicting cache |
| pack_line | output | LW | Evicted line |
| err | output | 1 | One-cycle pulse after an illegal message |

## Verification
The two functions that can fall in the same cycle are arbitration between channels and the request stall. A memory write acknowledge or owner data can arrive together with a request, and that request may target a line that is about to settle. The bench drives owner data together with a clean eviction, and a write acknowledge together with a read-shared request to another line. It judges the outcome from the three ready outputs and from which output channel fires in the following cycle. It also checks that the held request gets no response until it is presented again.

// File: rtl/msi_directory.sv
module msi_directory #(
  parameter int NCACHE = 4,
  parameter int NLINE  = 4,
  parameter int DW     = 8,
  localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int AW = $clog2(NCACHE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [LW-1:0]     req_line,
  input  logic [CW-1:0]     req_src,
  input  logic [DW-1:0]     req_data,
  input  logic              cdat_valid,
  output logic              cdat_ready,
  input  logic [LW-1:0]     cdat_line,
  input  logic [DW-1:0]     cdat_data,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_ack,
  input  logic [LW-1:0]     mem_rsp_line,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [LW-1:0]     mem_req_line,
  output logic [DW-1:0]     mem_req_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [1:0]        fwd_kind,
  output logic [LW-1:0]     fwd_line,
  output logic [NCACHE-1:0] fwd_dest,
  output logic [CW-1:0]     fwd_src,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [CW-1:0]     dat_dest,
  output logic [LW-1:0]     dat_line,
  output logic [DW-1:0]     dat_data,
  output logic [AW-1:0]     dat_acks,
  output logic              pack_valid,
  input  logic              pack_ready,
  output logic [CW-1:0]     pack_dest,
  output logic [LW-1:0]     pack_line,
  output logic              err
);
  typedef enum logic [2:0] {
    ST_I, ST_S, ST_M, ST_S_FWD, ST_S_RD, ST_M_RD, ST_I_WB, ST_S_WB
  } lst_t;

  lst_t              st   [NLINE];
  logic [NCACHE-1:0] shr  [NLINE];
  logic [NCACHE-1:0] own  [NLINE];
  logic [CW-1:0]     pend [NLINE];

  function automatic logic [AW-1:0] popc(input logic [NCACHE-1:0] v);
    popc = '0;
    for (int i = 0; i < NCACHE; i++) popc = popc + AW'(v[i]);
  endfunction

  logic              go, take, bad;
  logic [LW-1:0]     ln;
  lst_t              cs, n_st;
  logic [NCACHE-1:0] csh, cow, n_shr, n_own, rb;
  logic [CW-1:0]     n_pend;
  logic              s_mem, s_mw, s_fwd, s_dat, s_pack;
  logic [DW-1:0]     s_md;
  logic [1:0]        s_fk;
  logic [NCACHE-1:0] s_fd;
  logic [AW-1:0]     s_acks;

  assign go = (!mem_req_valid || mem_req_ready) && (!fwd_valid || fwd_ready) &&
              (!dat_valid || dat_ready) && (!pack_valid || pack_ready);
  assign take = req_ready || cdat_ready || mem_rsp_ready;
  assign rb = NCACHE'(1) << req_src;

  always_comb begin
    mem_rsp_ready = 1'b0; cdat_ready = 1'b0; req_ready = 1'b0; bad = 1'b0;
    ln = req_line;
    if (mem_rsp_valid) ln = mem_rsp_line;
    else if (cdat_valid) ln = cdat_line;
    cs = st[ln]; csh = shr[ln]; cow = own[ln];
    n_st = cs; n_shr = csh; n_own = cow; n_pend = pend[ln];
    s_mem = 1'b0; s_mw = 1'b0; s_md = '0; s_fwd = 1'b0; s_fk = 2'd0; s_fd = '0;
    s_dat = 1'b0; s_acks = '0; s_pack = 1'b0;
    if (go && mem_rsp_valid) begin
      mem_rsp_ready = 1'b1;
      if (!mem_rsp_ack) begin
        s_acks = cow[pend[ln]] ? popc(csh) : '0;
        s_dat = 1'b1;
        if (cs == ST_S_RD) n_st = ST_S;
        else if (cs == ST_M_RD) begin n_st = ST_M; n_shr = '0; end
        else bad = 1'b1;
      end else begin
        if (cs == ST_I_WB) n_st = ST_I;
        else if (cs == ST_S_WB) n_st = ST_S;
        else bad = 1'b1;
      end
    end else if (go && cdat_valid) begin
      cdat_ready = 1'b1;
      if (cs == ST_S_FWD) begin
        s_mem = 1'b1; s_mw = 1'b1; s_md = cdat_data; n_st = ST_S_WB;
      end else bad = 1'b1;
    end else if (go && req_valid) begin
      req_ready = 1'b1;
      case (req_type)
        2'd0: case (cs)
          ST_I, ST_S: begin
            s_mem = 1'b1; n_shr = csh | rb; n_pend = req_src; n_st = ST_S_RD;
          end
          ST_M: begin
            s_fwd = 1'b1; s_fk = 2'd0; s_fd = cow;
            n_shr = csh | rb | cow; n_own = '0; n_st = ST_S_FWD;
          end
          default: req_ready = 1'b0;
        endcase
        2'd1: case (cs)
          ST_I, ST_S: begin
            s_mem = 1'b1; n_shr = csh & ~rb; n_own = rb; n_pend = req_src; n_st = ST_M_RD;
            if (|(csh & ~rb)) begin s_fwd = 1'b1; s_fk = 2'd2; s_fd = csh & ~rb; end
          end
          ST_M: begin s_fwd = 1'b1; s_fk = 2'd1; s_fd = cow; n_own = rb; end
          default: req_ready = 1'b0;
        endcase
        2'd2: case (cs)
          ST_S: begin
            s_pack = 1'b1; n_shr = csh & ~rb;
            if (popc(csh) == AW'(1)) n_st = ST_I;
          end
          ST_S_FWD: begin s_pack = 1'b1; n_shr = csh & ~rb; end
          ST_S_RD, ST_S_WB:
            if (popc(csh) == AW'(1)) bad = 1'b1;
            else begin s_pack = 1'b1; n_shr = csh & ~rb; end
          default: s_pack = 1'b1;
        endcase
        default: if (cow[req_src]) begin
          if (cs == ST_M) begin
            s_mem = 1'b1; s_mw = 1'b1; s_md = req_data; n_own = '0; s_pack = 1'b1; n_st = ST_I_WB;
          end else bad = 1'b1;
        end else begin
          s_pack = 1'b1;
          if (cs == ST_S || cs == ST_S_FWD || cs == ST_S_RD || cs == ST_S_WB) n_shr = csh & ~rb;
        end
      endcase
    end
    if (n_st == ST_M && cs != ST_M && popc(n_own) != AW'(1)) bad = 1'b1;
    if (n_st == ST_I && cs != ST_I && (|n_shr || |n_own)) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0; fwd_valid <= 1'b0; dat_valid <= 1'b0; pack_valid <= 1'b0; err <= 1'b0;
      mem_req_write <= 1'b0; mem_req_line <= '0; mem_req_data <= '0;
      fwd_kind <= '0; fwd_line <= '0; fwd_dest <= '0; fwd_src <= '0;
      dat_dest <= '0; dat_line <= '0; dat_data <= '0; dat_acks <= '0;
      pack_dest <= '0; pack_line <= '0;
      for (int i = 0; i < NLINE; i++) begin
        st[i] <= ST_I; shr[i] <= '0; own[i] <= '0; pend[i] <= '0;
      end
    end else begin
      err <= take && bad;
      if (mem_req_ready) mem_req_valid <= 1'b0;
      if (fwd_ready) fwd_valid <= 1'b0;
      if (dat_ready) dat_valid <= 1'b0;
      if (pack_ready) pack_valid <= 1'b0;
      if (take && !bad) begin
        st[ln] <= n_st; shr[ln] <= n_shr; own[ln] <= n_own; pend[ln] <= n_pend;
        if (s_mem) begin
          mem_req_valid <= 1'b1; mem_req_write <= s_mw; mem_req_line <= ln; mem_req_data <= s_md;
        end
        if (s_fwd) begin
          fwd_valid <= 1'b1; fwd_kind <= s_fk; fwd_line <= ln; fwd_dest <= s_fd; fwd_src <= req_src;
        end
        if (s_dat) begin
          dat_valid <= 1'b1; dat_dest <= pend[ln]; dat_line <= ln; dat_data <= mem_rsp_data;
          dat_acks <= s_acks;
        end
        if (s_pack) begin
          pack_valid <= 1'b1; pack_dest <= req_src; pack_line <= ln;
        end
      end
    end
  end

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !(req_ready || cdat_ready));
  p_one_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, cdat_ready, mem_rsp_ready}));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line) && $stable(mem_req_write));
  p_no_take_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pack_valid && !pack_ready |-> !take);
  p_dat_from_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_valid) |-> $past(mem_rsp_valid && mem_rsp_ready));

  for (genvar g = 0; g < NLINE; g++) begin : g_line_chk
    p_m_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_M |-> $countones(own[g]) == 1);
    p_i_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_I |-> (own[g] == '0 && shr[g] == '0));
  end
endmodule

// File: tb/tb_msi_directory.sv
`timescale 1ns/1ps
module tb_msi_directory;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, cdat_valid = 0, mem_rsp_valid = 0, mem_rsp_ack = 0;
  logic [1:0] req_type = 0, req_line = 0, req_src = 0, cdat_line = 0, mem_rsp_line = 0;
  logic [7:0] req_data = 0, cdat_data = 0, mem_rsp_data = 0;
  logic mem_req_ready = 1, fwd_ready = 1, dat_ready = 1, pack_ready = 1;
  logic req_ready, cdat_ready, mem_rsp_ready;
  logic mem_req_valid, mem_req_write, fwd_valid, dat_valid, pack_valid, err;
  logic [1:0] mem_req_line, fwd_kind, fwd_line, fwd_src, dat_dest, dat_line, pack_dest, pack_line;
  logic [7:0] mem_req_data, dat_data;
  logic [3:0] fwd_dest;
  logic [2:0] dat_acks;

  msi_directory dut (.*);

  int n_chk = 0, n_bad = 0;
  bit a_req, a_c, a_m;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input logic [1:0] rt, input logic [1:0] rl, input logic [1:0] rs,
                     input logic [7:0] rd, input bit cv, input logic [1:0] cl, input logic [7:0] cd,
                     input bit mv, input bit mack, input logic [1:0] ml, input logic [7:0] md);
    @(negedge clk);
    req_valid = rv; req_type = rt; req_line = rl; req_src = rs; req_data = rd;
    cdat_valid = cv; cdat_line = cl; cdat_data = cd;
    mem_rsp_valid = mv; mem_rsp_ack = mack; mem_rsp_line = ml; mem_rsp_data = md;
    #1;
    a_req = req_ready; a_c = cdat_ready; a_m = mem_rsp_ready;
    @(posedge clk); #1;
    req_valid = 0; cdat_valid = 0; mem_rsp_valid = 0;
  endtask

  task automatic rq(input logic [1:0] t, input logic [1:0] l, input logic [1:0] s, input logic [7:0] d);
    cyc(1, t, l, s, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic mr(input bit ack, input logic [1:0] l, input logic [7:0] d);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, ack, l, d);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 dat_valid", dat_valid, 0);
    chk("R1 pack_valid", pack_valid, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_gets_flow();
    rq(0, 0, 1, 0);
    chk("R2 accepted", a_req, 1);
    chk("R2 mem read valid", mem_req_valid, 1);
    chk("R2 mem read kind", mem_req_write, 0);
    chk("R2 mem read line", mem_req_line, 0);
    rq(0, 0, 2, 0);
    chk("R7 stall in read wait", a_req, 0);
    chk("R7 no mem req", mem_req_valid, 0);
    mr(0, 0, 8'hA5);
    chk("R2 mem taken", a_m, 1);
    chk("R2 dat valid", dat_valid, 1);
    chk("R2 dat dest", dat_dest, 1);
    chk("R2 dat data", dat_data, 8'hA5);
    chk("R2 dat acks", dat_acks, 0);
    rq(0, 0, 2, 0);
    chk("R2 second sharer accepted", a_req, 1);
    chk("R2 second read", mem_req_valid, 1);
    mr(0, 0, 8'h5A);
    chk("R2 second dat dest", dat_dest, 2);
  endtask

  task automatic t_getm_from_s();
    rq(1, 0, 3, 0);
    chk("R3 mem read", mem_req_valid, 1);
    chk("R3 inv valid", fwd_valid, 1);
    chk("R3 inv kind", fwd_kind, 2);
    chk("R3 inv dest", fwd_dest, 4'b0110);
    mr(0, 0, 8'h11);
    chk("R3 dat dest", dat_dest, 3);
    chk("R3 dat acks", dat_acks, 2);
  endtask

  task automatic t_m_gets();
    rq(0, 0, 0, 0);
    chk("R4 fwd valid", fwd_valid, 1);
    chk("R4 fwd kind", fwd_kind, 0);
    chk("R4 fwd dest", fwd_dest, 4'b1000);
    chk("R4 fwd src", fwd_src, 0);
    chk("R4 no mem", mem_req_valid, 0);
    cyc(1, 2, 0, 0, 0, 1, 0, 8'h3C, 0, 0, 0, 0);
    chk("R8 owner data taken", a_c, 1);
    chk("R8 request held", a_req, 0);
    chk("R4 wb write", mem_req_write, 1);
    chk("R4 wb data", mem_req_data, 8'h3C);
    rq(0, 0, 1, 0);
    chk("R7 stall in write wait", a_req, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R8 mem ack taken", a_m, 1);
    chk("R8 request held vs mem", a_req, 0);
    chk("R8 no mem req", mem_req_valid, 0);
  endtask

  task automatic t_puts();
    rq(2, 0, 0, 0);
    chk("R6 not-last ack", pack_valid, 1);
    chk("R6 not-last dest", pack_dest, 0);
    chk("R6 not-last no fwd", fwd_valid, 0);
    rq(2, 0, 3, 0);
    chk("R6 last ack", pack_valid, 1);
    chk("R6 last dest", pack_dest, 3);
    rq(1, 0, 2, 0);
    chk("R6 invalid after last: read", mem_req_valid, 1);
    chk("R6 invalid after last: no inv", fwd_valid, 0);
    mr(0, 0, 8'h22);
    chk("R3 dat acks from invalid", dat_acks, 0);
  endtask

  task automatic t_m_getm();
    rq(1, 0, 1, 0);
    chk("R4 getm fwd kind", fwd_kind, 1);
    chk("R4 getm fwd dest", fwd_dest, 4'b0100);
    chk("R4 getm fwd src", fwd_src, 1);
    chk("R4 getm no mem", mem_req_valid, 0);
  endtask

  task automatic t_putm();
    rq(3, 0, 2, 0);
    chk("R9 non-owner ack", pack_valid, 1);
    chk("R9 non-owner no mem", mem_req_valid, 0);
    rq(3, 0, 1, 8'h77);
    chk("R5 wb valid", mem_req_valid, 1);
    chk("R5 wb write", mem_req_write, 1);
    chk("R5 wb data", mem_req_data, 8'h77);
    chk("R5 ack dest", pack_dest, 1);
    rq(0, 0, 3, 0);
    chk("R7 stall in evict wait", a_req, 0);
    mr(1, 0, 0);
    chk("R5 ack taken", a_m, 1);
    chk("R5 no err", err, 0);
    rq(2, 0, 1, 0);
    chk("R9 evict to invalid ack", pack_valid, 1);
    chk("R9 evict to invalid no mem", mem_req_valid, 0);
    chk("R9 evict to invalid no fwd", fwd_valid, 0);
    rq(1, 0, 0, 0);
    chk("R5 invalid: read", mem_req_valid, 1);
    chk("R5 invalid: no fwd", fwd_valid, 0);
    mr(0, 0, 8'h33);
    chk("R5 dat dest", dat_dest, 0);
  endtask

  task automatic t_err();
    mr(0, 2, 8'h44);
    chk("R10 consumed", a_m, 1);
    chk("R10 err pulse", err, 1);
    chk("R10 no dat", dat_valid, 0);
    idle();
    chk("R10 err clears", err, 0);
    rq(0, 1, 0, 0);
    rq(2, 1, 0, 0);
    chk("R10 last evict in read wait err", err, 1);
    chk("R10 no ack", pack_valid, 0);
    mr(0, 1, 8'h55);
    chk("R10 state kept dat", dat_valid, 1);
    chk("R10 state kept dest", dat_dest, 0);
  endtask

  task automatic t_backpressure();
    mem_req_ready = 0;
    rq(0, 3, 1, 0);
    chk("R11 valid", mem_req_valid, 1);
    idle();
    chk("R11 held valid", mem_req_valid, 1);
    chk("R11 held line", mem_req_line, 3);
    rq(0, 2, 1, 0);
    chk("R11 blocked", a_req, 0);
    mem_req_ready = 1;
    idle();
    chk("R11 drained", mem_req_valid, 0);
    rq(0, 2, 1, 0);
    chk("R11 accepted after drain", a_req, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_gets_flow();
    t_getm_from_s();
    t_m_gets();
    t_puts();
    t_m_getm();
    t_putm();
    t_err();
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule